// File: doc/BRIEF.md
# Software-Stepped I2C Bus Master

This block is a byte-level I2C bus master that software advances one bus phase at a time. A single 16-bit command word carries the byte to be sent, which is either a 7-bit target address with its direction bit or a data byte, together with bits that request START, STOP, read, master acknowledge and event clear. The engine performs the requested phase on open-drain SCL and SDA lines. After the ninth clock of every address or data byte it raises a master event and an interrupt. It then keeps SCL low, so the bus stays held until software writes the next command with the event-clear bit set.

Software reads a status byte that shows the target's acknowledge of the last transmitted byte, the transfer direction and a busy flag. It reads the event byte, which holds the master event and an overrun error flag, and a data register that holds the last received byte. An 8-bit divider sets the SCL rate to 2 MHz divided by its value. Each bit is built from four equal quarter phases, and each quarter lasts divider × CLK_HZ / 8 MHz system clocks.

The register port takes halfword writes with two byte-lane enables. Reads are single-byte and combinational by byte address. Byte offsets: 0 status (read only), 1 event, 2 received data (read only), 4–5 command (halfword), 12 divider.

Top module: `i2c_step_master`

## Requirements
- R1: After reset SCL and SDA are released, status (offset 0) and event (offset 1) read 0, the interrupt is low and the divider (offset 12) reads DIV_RST.
- R2: A command with bit 0 (START) set while the bus is idle produces a START condition followed by the address byte {cmd[15:9], cmd[2]}, MSB first, and SDA changes only while SCL is low during a byte.
- R3: When the ninth clock of an address or data byte ends, event bit 4 (offset 1) is set, the interrupt rises, SCL is held low and no further bus edges occur until a command with bit 7 (event clear) is written.
- R4: Status bit 3 is 1 when the target acknowledged the last transmitted byte and 0 when it did not. Status bit 2 is the direction (1 = read) taken from cmd[2] of the last address phase. Status bit 0 is 1 while the bus is not idle.
- R5: In a write transfer, a held-state command with bit 7 set and bits 0 and 1 clear transmits cmd[15:8] as the next data byte.
- R6: In a read transfer, the same kind of command receives one byte, which then reads back at offset 2. The master drives ACK (SDA low) in the ninth clock when cmd[3] is set and NACK when it is clear.
- R7: Event clear with bit 1 (STOP) produces a STOP condition, returns the bus to idle with both lines released and clears the event. STOP takes priority over START in the same command.
- R8: Event clear with bit 0 set while the bus is held produces a repeated START without a STOP, followed by the new address byte, and updates the direction.
- R9: One SCL period lasts 4 × max(div,1) × CLK_HZ / 8 MHz clocks, so the SCL rate is 2 MHz / div. A divider of 0 acts as 1.
- R10: A command written while a START, byte or STOP phase is in progress sets the overrun flag (event bit 5) and the interrupt. Writing 0 to offset 1 clears bit 5 and leaves bit 4 unchanged.
- R11: A command without bit 7, written while the bus is held, is ignored: the event stays set and no bus edge follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte address of the written halfword (bit 0 ignored) |
| wr_be | input | 2 | Byte-lane enables (bit 0 = low byte) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Byte address for reads |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Master event or overrun pending |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Write transfers of random length with random bytes at random divider values are compared byte for byte against what a behavioural target on the open-drain wires records. This separates correct MSB-first shifting from reversed or dropped bits. Directed patterns cover a wrong address and a target NACK on the second byte, which separate the two values of the acknowledge status bit. A write followed by a repeated START into a multi-byte read checks received data and the master's ACK/NACK sequence against the target's own log, which tells the repeated START apart from a STOP followed by a START. Further cases cover an overrun during START, a command without event clear while the bus is held, a combined STOP+START command, and the measured SCL period at divider 3 and divider 0.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;

    // command word bit positions
    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;
    localparam int CMD_RD    = 2;
    localparam int CMD_ACK   = 3;
    localparam int CMD_CLR   = 7;

    // event byte bit positions
    localparam int EVT_MASTER = 4;
    localparam int EVT_OVR    = 5;

    // register halfword indices (byte address >> 1)
    localparam logic [2:0] HW_STAT = 3'd0;
    localparam logic [2:0] HW_CMD  = 3'd2;
    localparam logic [2:0] HW_DIV  = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_HOLD,
        ST_STOP
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [1:0] qtr;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic [7:0] rx;
        logic [7:0] div;
        logic       scl;
        logic       sda;
        logic       ev;
        logic       ovr;
        logic       ack;
        logic       dir;
        logic       xmit;
        logic       acken;
    } eng_t;

endpackage

// File: rtl/i2c_step_sync.sv
module i2c_step_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= '1;
                end else if (g == 0) begin
                    stg_q[g] <= d;
                end else begin
                    stg_q[g] <= stg_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_step_qtick.sv
module i2c_step_qtick #(
    parameter int PRE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] div,
    output logic       tick
);
    localparam int CW = 8 + $clog2(PRE + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;
    logic [7:0]    eff;

    always_comb begin
        eff   = (div == 8'd0) ? 8'd1 : div;
        lim   = CW'(eff) * CW'(PRE) - CW'(1);
        tick  = (cnt_q >= lim);
        cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
    import i2c_step_pkg::*;
#(
    parameter int         CLK_HZ  = 32_000_000,
    parameter logic [7:0] DIV_RST = 8'd20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        irq,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe
);
    localparam int PRE = (CLK_HZ / 8_000_000 < 1) ? 1 : CLK_HZ / 8_000_000;

    eng_t        s_d, s_q;
    logic        tick;
    logic [1:0]  line_s;
    logic        scl_s, sda_s;
    logic        wr_evt, wr_cmd, wr_div, adv;
    logic [15:0] cmd;

    i2c_step_sync #(.W(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_step_qtick #(.PRE(PRE)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(s_q.div), .tick(tick)
    );

    assign wr_evt = wr_en && (wr_addr[3:1] == HW_STAT) && wr_be[1];
    assign wr_cmd = wr_en && (wr_addr[3:1] == HW_CMD) && (|wr_be);
    assign wr_div = wr_en && (wr_addr[3:1] == HW_DIV) && wr_be[0];
    assign cmd    = {wr_be[1] ? wr_data[15:8] : 8'h00, wr_be[0] ? wr_data[7:0] : 8'h00};

    always_comb begin
        s_d = s_q;
        adv = 1'b0;
        if (wr_div) s_d.div = wr_data[7:0];
        if (wr_evt) s_d.ovr = s_q.ovr & wr_data[8+EVT_OVR];

        // quarter-phase sequencer
        if (tick) begin
            adv = 1'b1;
            case (s_q.ph)
                ST_START: begin
                    case (s_q.qtr)
                        2'd0:    s_d.sda = 1'b1;
                        2'd1:    s_d.scl = 1'b1;
                        2'd2:    s_d.sda = 1'b0;
                        default: begin
                            s_d.scl  = 1'b0;
                            s_d.ph   = ST_BIT;
                            s_d.bitn = 4'd0;
                        end
                    endcase
                end
                ST_BIT: begin
                    case (s_q.qtr)
                        2'd0: s_d.sda = (s_q.bitn == 4'd8) ? (s_q.xmit | ~s_q.acken)
                                                           : (s_q.xmit ? s_q.sh[7] : 1'b1);
                        2'd1: s_d.scl = 1'b1;
                        2'd2: begin
                            if (!scl_s) begin
                                adv = 1'b0;               // line still low: wait
                            end else if (s_q.bitn == 4'd8) begin
                                if (s_q.xmit) s_d.ack = ~sda_s;
                                else          s_d.rx  = s_q.sh;
                            end else begin
                                s_d.sh = {s_q.sh[6:0], sda_s};
                            end
                        end
                        default: begin
                            s_d.scl = 1'b0;
                            if (s_q.bitn == 4'd8) begin
                                s_d.ph = ST_HOLD;
                                s_d.ev = 1'b1;
                            end else begin
                                s_d.bitn = s_q.bitn + 4'd1;
                            end
                        end
                    endcase
                end
                ST_STOP: begin
                    case (s_q.qtr)
                        2'd0:    s_d.sda = 1'b0;
                        2'd1:    s_d.scl = 1'b1;
                        2'd2:    s_d.sda = 1'b1;
                        default: s_d.ph  = ST_IDLE;
                    endcase
                end
                default: adv = 1'b0;
            endcase
        end
        s_d.qtr = s_q.qtr + {1'b0, adv};

        // command decode
        if (wr_cmd) begin
            case (s_q.ph)
                ST_IDLE: begin
                    if (cmd[CMD_START]) begin
                        s_d.ph   = ST_START;
                        s_d.qtr  = 2'd0;
                        s_d.sh   = {cmd[15:9], cmd[CMD_RD]};
                        s_d.dir  = cmd[CMD_RD];
                        s_d.xmit = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cmd[CMD_CLR]) begin
                        s_d.ev  = 1'b0;
                        s_d.qtr = 2'd0;
                        if (cmd[CMD_STOP]) begin
                            s_d.ph = ST_STOP;
                        end else if (cmd[CMD_START]) begin
                            s_d.ph   = ST_START;
                            s_d.sh   = {cmd[15:9], cmd[CMD_RD]};
                            s_d.dir  = cmd[CMD_RD];
                            s_d.xmit = 1'b1;
                        end else begin
                            s_d.ph    = ST_BIT;
                            s_d.bitn  = 4'd0;
                            s_d.sh    = cmd[15:8];
                            s_d.xmit  = ~s_q.dir;
                            s_d.acken = cmd[CMD_ACK];
                        end
                    end
                end
                default: s_d.ovr = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ph    <= ST_IDLE;
            s_q.scl   <= 1'b1;
            s_q.sda   <= 1'b1;
            s_q.div   <= DIV_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (rd_addr)
            4'd0:    rd_data = {4'b0, s_q.ack, s_q.dir, 1'b0, s_q.ph != ST_IDLE};
            4'd1:    rd_data = {2'b0, s_q.ovr, s_q.ev, 4'b0};
            4'd2:    rd_data = s_q.rx;
            4'd12:   rd_data = s_q.div;
            default: rd_data = 8'h00;
        endcase
    end

    assign irq    = s_q.ev | s_q.ovr;
    assign scl_oe = ~s_q.scl;
    assign sda_oe = ~s_q.sda;
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk
    import i2c_step_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input phase_e     ph,
    input logic [3:0] bitn,
    input logic       xmit,
    input logic       acken,
    input logic       ovr,
    input logic       ev,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [1:0] wr_be
);
    p_sda_steady_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == ST_BIT && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

    p_hold_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == ST_HOLD && $past(ph) == ST_HOLD) |-> (scl_oe && $stable(sda_oe)));

    p_event_after_ninth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev) |-> ($past(ph) == ST_BIT && $past(bitn) == 4'd8));

    p_hold_signals_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == ST_HOLD) |-> irq);

    p_master_ack_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == ST_BIT && !xmit && bitn == 4'd8 && !scl_oe) |-> (sda_oe == acken));

    p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == ST_IDLE && $past(ph) == ST_IDLE) |-> (!scl_oe && !sda_oe));

    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(wr_en && wr_addr[3:1] == 3'd0 && wr_be[1])) |=> ovr);
endmodule

bind i2c_step_master i2c_step_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ph(s_q.ph), .bitn(s_q.bitn), .xmit(s_q.xmit),
    .acken(s_q.acken), .ovr(s_q.ovr), .ev(s_q.ev), .irq(irq), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be)
);

// File: tb/i2c_step_master_tb_top.sv
module i2c_step_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 32_000_000;
    localparam int PRE        = CLK_HZ / 8_000_000;
    localparam logic [6:0] TADDR = 7'h5A;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0;
    logic [3:0] wr_addr = 0, rd_addr = 0;
    logic [1:0] wr_be = 0;
    logic [15:0] wr_data = 0;
    logic [7:0] rd_data;
    logic irq, scl_oe, sda_oe, scl_w, sda_w;
    logic t_sda_low = 0;

    assign scl_w = !scl_oe;
    assign sda_w = !sda_oe && !t_sda_low;

    i2c_step_master #(.CLK_HZ(CLK_HZ), .DIV_RST(8'd20)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
        .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc++;

    // ---------------- behavioural target ----------------
    int tbit = 0, tmode = 0, nstart = 0, nstop = 0, nfall = 0, nack_after = 0;
    logic [7:0] tsh = 0, ttx = 0, last_addr = 0;
    logic trw = 0, tmack = 0;
    logic [7:0] rxlog[$];
    logic [7:0] txq[$];
    logic mack_log[$];

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        nstart++; tmode = 1; tbit = -1; t_sda_low = 0;
    end
    always @(posedge sda_w) if (scl_w === 1'b1 && rst_n) begin
        nstop++; tmode = 0; t_sda_low = 0;
    end
    always @(posedge scl_w) begin
        if ((tmode == 1 || tmode == 2) && tbit >= 0 && tbit < 8) tsh = {tsh[6:0], sda_w};
        if (tmode == 3 && tbit == 8) tmack = !sda_w;
    end
    always @(negedge scl_w) begin
        nfall++;
        if (tmode != 0) begin
            if (tbit < 0) tbit = 0;
            else if (tbit == 7) begin
                tbit = 8;
                if (tmode == 1) begin
                    last_addr = tsh;
                    if (tsh[7:1] == TADDR) begin trw = tsh[0]; t_sda_low = 1; end
                    else tmode = 0;
                end else if (tmode == 2) begin
                    rxlog.push_back(tsh);
                    t_sda_low = (nack_after == rxlog.size()) ? 1'b0 : 1'b1;
                end else t_sda_low = 0;
            end else if (tbit == 8) begin
                tbit = 0; t_sda_low = 0;
                if (tmode == 1) tmode = trw ? 3 : 2;
                else if (tmode == 3) begin
                    mack_log.push_back(tmack);
                    if (!tmack) tmode = 0;
                end
                if (tmode == 3) begin
                    ttx = (txq.size() > 0) ? txq.pop_front() : 8'hFF;
                    t_sda_low = !ttx[7];
                end
            end else begin
                tbit++;
                if (tmode == 3) t_sda_low = !ttx[7 - tbit];
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_be = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic wait_ev(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); rd(4'd1, v);
            if (v[4]) return;
        end
        chk({tag, " event timeout"}, 0, 1);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); rd(4'd0, v);
            if (!v[0]) return;
        end
        chk({tag, " idle timeout"}, 0, 1);
    endtask

    function automatic logic [15:0] c_addr(input logic [6:0] a, input logic rdb, input logic clr);
        return {a, 9'b0} | {13'b0, rdb, 2'b01} | {8'b0, clr, 7'b0};
    endfunction
    function automatic logic [15:0] c_data(input logic [7:0] b);
        return {b, 8'h80};
    endfunction
    function automatic logic [15:0] c_read(input logic ack);
        return 16'h0084 | {12'b0, ack, 3'b0};
    endfunction
    localparam logic [15:0] C_STOP = 16'h0082;

    task automatic write_xfer(input int len);
        logic [7:0] v;
        logic [7:0] exp_b[$];
        int s0, f0;
        rxlog.delete();
        s0 = nstop;
        wr(4'd4, 2'b11, c_addr(TADDR, 1'b0, 1'b0));
        wait_ev("R3");
        rd(4'd1, v); chk("R3 event byte after address", v, 8'h10);
        chk("R3 irq after address", irq, 1);
        chk("R2 address byte seen by target", last_addr, {TADDR, 1'b0});
        rd(4'd0, v); chk("R4 status after acked write address", v, 8'h09);
        f0 = nfall;
        repeat (200) @(negedge clk);
        chk("R3 SCL held low while event pending", scl_oe, 1);
        chk("R3 no SCL edge while event pending", nfall, f0);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            exp_b.push_back(b);
            wr(4'd4, 2'b11, c_data(b));
            wait_ev("R5");
            rd(4'd0, v); chk("R4 ack status after data byte", v[3], 1);
        end
        wr(4'd4, 2'b01, C_STOP);
        wait_idle("R7");
        chk("R7 STOP seen", nstop, s0 + 1);
        chk("R7 lines released", {scl_oe, sda_oe}, 0);
        chk("R7 irq cleared", irq, 0);
        chk("R5 byte count at target", rxlog.size(), len);
        for (int i = 0; i < len && i < rxlog.size(); i++)
            chk("R5 data byte at target", rxlog[i], exp_b[i]);
    endtask

    task automatic measure(output int clks);
        time t0;
        @(posedge scl_w); t0 = $time;
        @(posedge scl_w); clks = int'(($time - t0) / CLK_PERIOD);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        wait (cyc == 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] v;
        logic [7:0] tx_b[$];
        int k, s0, p0, f0;
        void'($urandom(32'h1C2D));
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(4'd0, v); chk("R1 status after reset", v, 0);
        rd(4'd1, v); chk("R1 event after reset", v, 0);
        rd(4'd12, v); chk("R1 divider after reset", v, 20);
        chk("R1 irq after reset", irq, 0);
        chk("R1 lines released after reset", {scl_oe, sda_oe}, 0);

        // random write transfers at random dividers
        for (int it = 0; it < 4; it++) begin
            wr(4'd12, 2'b01, 16'(1 + ($urandom % 3)));
            write_xfer(1 + int'($urandom % 4));
        end
        wr(4'd12, 2'b01, 16'd2);

        // R4 wrong address -> NACK
        wr(4'd4, 2'b11, c_addr(7'h11, 1'b0, 1'b0));
        wait_ev("R4");
        rd(4'd0, v); chk("R4 status after unacked address", v, 8'h01);
        wr(4'd4, 2'b01, C_STOP); wait_idle("R7");

        // R4 target NACKs second data byte
        nack_after = 2; rxlog.delete();
        wr(4'd4, 2'b11, c_addr(TADDR, 1'b0, 1'b0)); wait_ev("R4");
        wr(4'd4, 2'b11, c_data(8'h3E)); wait_ev("R4");
        rd(4'd0, v); chk("R4 ack bit on first byte", v[3], 1);
        wr(4'd4, 2'b11, c_data(8'hC1)); wait_ev("R4");
        rd(4'd0, v); chk("R4 ack bit on nacked byte", v[3], 0);
        wr(4'd4, 2'b01, C_STOP); wait_idle("R7");
        nack_after = 0;

        // R8 / R6 write pointer, repeated START, multi-byte read
        k = 3;
        tx_b.delete(); mack_log.delete();
        for (int i = 0; i < k; i++) tx_b.push_back(8'($urandom));
        foreach (tx_b[i]) txq.push_back(tx_b[i]);
        wr(4'd4, 2'b11, c_addr(TADDR, 1'b0, 1'b0)); wait_ev("R8");
        wr(4'd4, 2'b11, c_data(8'hA5)); wait_ev("R8");
        s0 = nstop; p0 = nstart;
        wr(4'd4, 2'b11, c_addr(TADDR, 1'b1, 1'b1)); wait_ev("R8");
        chk("R8 repeated START count", nstart, p0 + 1);
        chk("R8 no STOP before repeated START", nstop, s0);
        chk("R8 read address byte at target", last_addr, {TADDR, 1'b1});
        rd(4'd0, v); chk("R8 status shows read direction", v, 8'h0D);
        for (int i = 0; i < k; i++) begin
            wr(4'd4, 2'b01, c_read(i < k - 1)); wait_ev("R6");
            rd(4'd2, v); chk("R6 received byte", v, tx_b[i]);
        end
        wr(4'd4, 2'b01, C_STOP); wait_idle("R7");
        chk("R6 master ack count", mack_log.size(), k);
        for (int i = 0; i < k && i < mack_log.size(); i++)
            chk("R6 master ACK/NACK in ninth clock", mack_log[i], (i < k - 1) ? 1 : 0);

        // R10 overrun while START runs
        wr(4'd4, 2'b11, c_addr(TADDR, 1'b0, 1'b0));
        wr(4'd4, 2'b11, c_data(8'h77));
        rd(4'd1, v); chk("R10 overrun flag set", v, 8'h20);
        chk("R10 irq on overrun", irq, 1);
        wait_ev("R10");
        rd(4'd1, v); chk("R10 event and overrun both set", v, 8'h30);
        wr(4'd0, 2'b10, 16'h0000);
        rd(4'd1, v); chk("R10 zero write clears overrun only", v, 8'h10);

        // R11 command without event clear is ignored
        f0 = nfall; k = rxlog.size();
        wr(4'd4, 2'b11, 16'h3C00);
        repeat (400) @(negedge clk);
        rd(4'd1, v); chk("R11 event still pending", v, 8'h10);
        chk("R11 no SCL edge", nfall, f0);
        chk("R11 no byte at target", rxlog.size(), k);

        // R7 STOP wins over START in one command
        s0 = nstop; p0 = nstart;
        wr(4'd4, 2'b11, 16'h0083 | c_addr(TADDR, 1'b0, 1'b1));
        wait_idle("R7");
        chk("R7 STOP priority: stop seen", nstop, s0 + 1);
        chk("R7 STOP priority: no new START", nstart, p0);

        // R9 SCL period
        wr(4'd12, 2'b01, 16'd3);
        wr(4'd4, 2'b11, c_addr(TADDR, 1'b0, 1'b0));
        measure(k); chk("R9 SCL period div=3", k, 4 * 3 * PRE);
        wait_ev("R9"); wr(4'd4, 2'b01, C_STOP); wait_idle("R9");
        wr(4'd12, 2'b01, 16'd0);
        wr(4'd4, 2'b11, c_addr(TADDR, 1'b0, 1'b0));
        measure(k); chk("R9 SCL period div=0", k, 4 * PRE);
        wait_ev("R9"); wr(4'd4, 2'b01, C_STOP); wait_idle("R9");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule